// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block turns one high-level flash request into the full series of single-bit SPI command frames a serial NOR part needs. A request names one of four operations (read, page program, sector erase, identification read), a 24-bit address and a byte count. Write data arrives one byte at a time from a source that the block paces with a take strobe. Read and ID bytes leave on a valid-qualified output.

Below the block sits a byte exchange engine. The sequencer raises a chip-select level for the length of a frame and hands over one byte at a time with a start pulse. The engine replies with a done pulse and the byte it received.

For program and erase, the block runs the whole safe sequence without help. It sends a stand-alone write-enable frame, then reads status to confirm that the write-enable latch is set. Only then does it issue the command, after which it polls status until the busy bit clears. A poll limit supplied as an input bounds this wait. A malformed request is refused before anything reaches the flash.

Top module: `nor_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `spi_cs`, `xfer_start` and `done` are 0.
- R2: A read (`req_op`=0) with length N≥1 sends one frame of opcode 0x03, then the three address bytes high byte first, then N filler bytes. Each of the N received bytes appears once on `rd_data` with `rd_valid`, in order. The request ends with `done` and `err_kind`=0.
- R3: An ID read (`req_op`=3) sends one four-byte frame, opcode 0x9F and then three filler bytes, with no address. The three received bytes are returned on `rd_data` in order.
- R4: A program (`req_op`=1) or erase (`req_op`=2) begins with a frame that holds only the single byte 0x06. Chip select falls after that byte.
- R5: After the write-enable frame comes a two-byte status frame (0x05 plus one filler byte). If bit 1 of the returned status is 0, the request ends with `err_kind`=2 and no command frame is sent.
- R6: Once the write-enable latch has been confirmed, a program sends opcode 0x02, the address high byte first, and N data bytes taken from `wr_data`. `wr_take` pulses exactly once per data byte.
- R7: Once the write-enable latch has been confirmed, an erase sends a four-byte frame: opcode 0x20 and the address high byte first.
- R8: After the command frame, two-byte 0x05 status frames repeat until a status with bit 0 (busy) equal to 0 is returned. The request then ends with `err_kind`=0.
- R9: If max(`poll_limit`,1) status frames in a row return busy, the request ends with `err_kind`=3 and no further frame is sent.
- R10: A bad request ends with `err_kind`=1 and never raises `spi_cs`. A request is bad when it is a program with N=0, a program whose low address byte plus N exceeds 256, or a read with N=0.
- R11: Chip select is low for at least one cycle between frames, and at most one byte is in flight with the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 ID |
| req_addr | input | 24 | Flash byte address |
| req_len | input | 9 | Byte count (read, program) |
| wr_data | input | 8 | Current write byte |
| wr_take | output | 1 | `wr_data` consumed this cycle |
| rd_data | output | 8 | Returned read or ID byte |
| rd_valid | output | 1 | `rd_data` valid |
| poll_limit | input | 24 | Maximum busy status reads |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion carried an error |
| err_kind | output | 2 | 0 ok, 1 bad request, 2 latch not set, 3 poll timeout |
| spi_cs | output | 1 | Frame active (chip select asserted) |
| xfer_start | output | 1 | Start one byte exchange |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_done | input | 1 | Byte exchange finished |
| xfer_rx | input | 8 | Byte shifted in |

## Verification
The assertions check several properties on every cycle. They confirm that a refused request leaves chip select low and completes at once, and that write bytes are only taken inside a program command frame. They also confirm that a command frame never starts before the latch check has passed, that chip select drops for a cycle after each frame, and that the engine never sees two starts in a row. The bench scenarios are needed for everything that depends on what the flash answers. This covers the exact frame order and lengths, the address and data bytes, the number of polls against the busy time and the limit, the error codes, and the read data coming back intact.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam int ADDR_W     = 24;
  localparam int LEN_W      = 9;
  localparam int PAGE_BYTES = 256;
  localparam int HDR_ADDR   = 4;

  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_STAT  = 8'h05;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_ID    = 8'h9F;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_WEL_BIT  = 1;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_ID    = 2'd3
  } nor_op_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_BADREQ  = 2'd1,
    ERR_WEL     = 2'd2,
    ERR_TIMEOUT = 2'd3
  } nor_err_e;

  // True when a program of n bytes starting at low byte lo stays in one page.
  function automatic logic page_fits(input logic [7:0] lo, input logic [LEN_W-1:0] n);
    logic [LEN_W:0] sum;
    sum = {{(LEN_W+1-8){1'b0}}, lo} + {1'b0, n};
    return (n != '0) && (sum <= (LEN_W+1)'(PAGE_BYTES));
  endfunction

  // Number of bytes in a frame: opcode, optional address, data.
  function automatic logic [LEN_W:0] frame_total(input logic has_addr, input logic [LEN_W-1:0] n);
    return {1'b0, n} + (has_addr ? (LEN_W+1)'(HDR_ADDR) : (LEN_W+1)'(1));
  endfunction

endpackage

// File: rtl/nor_seq_reqchk.sv
module nor_seq_reqchk
  import nor_seq_pkg::*;
(
  input  logic [1:0]       op,
  input  logic [7:0]       addr_lo,
  input  logic [LEN_W-1:0] len,
  output logic             bad
);

  logic prog_bad;
  logic read_bad;

  always_comb begin
    prog_bad = (nor_op_e'(op) == OP_PROG) && !page_fits(addr_lo, len);
    read_bad = (nor_op_e'(op) == OP_READ) && (len == '0);
    bad      = prog_bad || read_bad;
  end

endmodule

// File: rtl/nor_seq_poll_timer.sv
module nor_seq_poll_timer #(
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [TMO_W-1:0] limit,
  output logic             last
);

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign last = (({1'b0, cnt} + (TMO_W+1)'(1)) >= {1'b0, limit});

  // R9
  bump_clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bump && clear));

  // R9
  bump_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> !last);

endmodule

// File: rtl/nor_seq_frame.sv
module nor_seq_frame
  import nor_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              has_addr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  n_data,
  input  logic              is_write,
  input  logic              emit_rd,
  input  logic [7:0]        wr_data,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx,
  output logic              cs,
  output logic              xfer_start,
  output logic [7:0]        xfer_tx,
  output logic              wr_take,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [7:0]        last_rx,
  output logic              frame_done
);

  localparam int CNT_W = LEN_W + 1;

  typedef enum logic [1:0] {F_IDLE, F_SEND, F_WAIT, F_DONE} fr_st_e;

  fr_st_e           st;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] hdr;
  logic             data_phase;
  logic             last_byte;

  function automatic logic [7:0] tx_pick(input logic [CNT_W-1:0] i, input logic ha,
                                         input logic [7:0] opc, input logic [ADDR_W-1:0] a,
                                         input logic wr, input logic [7:0] wd);
    if (i == '0)                   return opc;
    if (ha && i == CNT_W'(1))      return a[23:16];
    if (ha && i == CNT_W'(2))      return a[15:8];
    if (ha && i == CNT_W'(3))      return a[7:0];
    return wr ? wd : 8'h00;
  endfunction

  always_comb begin
    total      = frame_total(has_addr, n_data);
    hdr        = has_addr ? CNT_W'(HDR_ADDR) : CNT_W'(1);
    data_phase = (idx >= hdr);
    last_byte  = (idx == total - CNT_W'(1));
    cs         = (st == F_SEND) || (st == F_WAIT);
    xfer_start = (st == F_SEND);
    xfer_tx    = tx_pick(idx, has_addr, opcode, addr, is_write, wr_data);
    wr_take    = (st == F_SEND) && is_write && data_phase;
    frame_done = (st == F_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= F_IDLE;
      idx      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      last_rx  <= 8'h00;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        F_IDLE: if (start) begin
          idx <= '0;
          st  <= F_SEND;
        end
        F_SEND: st <= F_WAIT;
        F_WAIT: if (xfer_done) begin
          last_rx  <= xfer_rx;
          rd_data  <= xfer_rx;
          rd_valid <= data_phase && emit_rd;
          if (last_byte) st <= F_DONE;
          else begin
            idx <= idx + 1'b1;
            st  <= F_SEND;
          end
        end
        F_DONE: st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  // R11
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !cs);

  // R11
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_seq_pkg::*;
#(
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [8:0]       req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic [TMO_W-1:0] poll_limit,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_kind,
  output logic             spi_cs,
  output logic             xfer_start,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_done,
  input  logic [7:0]       xfer_rx
);

  typedef enum logic [2:0] {
    T_IDLE, T_WREN, T_WELCHK, T_CMD, T_POLL, T_XFER, T_FINISH
  } top_st_e;

  top_st_e           st;
  nor_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  nor_err_e          err_q;
  logic              fr_busy;
  logic              wel_ok;

  logic              req_bad;
  logic              accept;
  logic              in_frame_st;
  logic              fr_start;
  logic              fr_done;
  logic [7:0]        fr_last_rx;
  logic [7:0]        f_op;
  logic              f_addr_en;
  logic [LEN_W-1:0]  f_n;
  logic              f_wr;
  logic              f_emit;
  logic              tmr_clear;
  logic              tmr_bump;
  logic              tmr_last;
  logic              stat_busy;
  logic              stat_wel;

  nor_seq_reqchk u_reqchk (
    .op      (req_op),
    .addr_lo (req_addr[7:0]),
    .len     (req_len),
    .bad     (req_bad)
  );

  // Frame contents for the current step.
  always_comb begin
    f_op      = 8'h00;
    f_addr_en = 1'b0;
    f_n       = '0;
    f_wr      = 1'b0;
    f_emit    = 1'b0;
    case (st)
      T_WREN: f_op = CMD_WREN;
      T_WELCHK, T_POLL: begin
        f_op = CMD_STAT;
        f_n  = LEN_W'(1);
      end
      T_CMD: begin
        f_addr_en = 1'b1;
        if (op_q == OP_PROG) begin
          f_op = CMD_PROG;
          f_n  = len_q;
          f_wr = 1'b1;
        end else begin
          f_op = CMD_ERASE;
        end
      end
      T_XFER: begin
        f_emit = 1'b1;
        if (op_q == OP_ID) begin
          f_op = CMD_ID;
          f_n  = LEN_W'(3);
        end else begin
          f_op      = CMD_READ;
          f_addr_en = 1'b1;
          f_n       = len_q;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    accept      = (st == T_IDLE) && req_valid;
    in_frame_st = (st == T_WREN) || (st == T_WELCHK) || (st == T_CMD) ||
                  (st == T_POLL) || (st == T_XFER);
    fr_start    = in_frame_st && !fr_busy;
    stat_busy   = fr_last_rx[STAT_BUSY_BIT];
    stat_wel    = fr_last_rx[STAT_WEL_BIT];
    tmr_clear   = fr_done && (st == T_CMD);
    tmr_bump    = fr_done && (st == T_POLL) && stat_busy && !tmr_last;
  end

  nor_seq_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fr_start),
    .opcode     (f_op),
    .has_addr   (f_addr_en),
    .addr       (addr_q),
    .n_data     (f_n),
    .is_write   (f_wr),
    .emit_rd    (f_emit),
    .wr_data    (wr_data),
    .xfer_done  (xfer_done),
    .xfer_rx    (xfer_rx),
    .cs         (spi_cs),
    .xfer_start (xfer_start),
    .xfer_tx    (xfer_tx),
    .wr_take    (wr_take),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .last_rx    (fr_last_rx),
    .frame_done (fr_done)
  );

  nor_seq_poll_timer #(.TMO_W(TMO_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .bump  (tmr_bump),
    .limit (poll_limit),
    .last  (tmr_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= T_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      len_q   <= '0;
      err_q   <= ERR_NONE;
      fr_busy <= 1'b0;
      wel_ok  <= 1'b0;
    end else begin
      if (fr_start)     fr_busy <= 1'b1;
      else if (fr_done) fr_busy <= 1'b0;
      case (st)
        T_IDLE: if (accept) begin
          op_q   <= nor_op_e'(req_op);
          addr_q <= req_addr;
          len_q  <= req_len;
          wel_ok <= 1'b0;
          if (req_bad) begin
            err_q <= ERR_BADREQ;
            st    <= T_FINISH;
          end else begin
            err_q <= ERR_NONE;
            st    <= (nor_op_e'(req_op) == OP_READ || nor_op_e'(req_op) == OP_ID) ? T_XFER : T_WREN;
          end
        end
        T_WREN: if (fr_done) st <= T_WELCHK;
        T_WELCHK: if (fr_done) begin
          if (stat_wel) begin
            wel_ok <= 1'b1;
            st     <= T_CMD;
          end else begin
            err_q <= ERR_WEL;
            st    <= T_FINISH;
          end
        end
        T_CMD: if (fr_done) st <= T_POLL;
        T_POLL: if (fr_done) begin
          if (!stat_busy) st <= T_FINISH;
          else if (tmr_last) begin
            err_q <= ERR_TIMEOUT;
            st    <= T_FINISH;
          end
        end
        T_XFER: if (fr_done) st <= T_FINISH;
        T_FINISH: st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end

  assign req_ready = (st == T_IDLE);
  assign done      = (st == T_FINISH);
  assign err       = done && (err_q != ERR_NONE);
  assign err_kind  = err_q;

  // R10
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_bad) |=> (done && !spi_cs));

  // R6
  wr_take_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (st == T_CMD && op_q == OP_PROG));

  // R5
  cmd_after_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_CMD) |-> wel_ok);

  // R2
  rd_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (st == T_XFER));

  // R8
  done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !spi_cs));

endmodule

// File: tb/nor_seq_bench.sv
module nor_seq_bench;

  localparam int TMO_W = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_op = 2'd0;
  logic [23:0]      req_addr = '0;
  logic [8:0]       req_len = '0;
  logic [7:0]       wr_data;
  logic             wr_take;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic [TMO_W-1:0] poll_limit = 24'd4;
  logic             done;
  logic             err;
  logic [1:0]       err_kind;
  logic             spi_cs;
  logic             xfer_start;
  logic [7:0]       xfer_tx;
  logic             xfer_done;
  logic [7:0]       xfer_rx;

  always #10 clk = ~clk;

  nor_seq #(.TMO_W(TMO_W)) u_nor_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .poll_limit(poll_limit), .done(done), .err(err), .err_kind(err_kind),
    .spi_cs(spi_cs), .xfer_start(xfer_start), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx)
  );

  int checks = 0;
  int failures = 0;

  // Flash model and byte engine.
  logic [7:0] fbuf[0:299];
  logic [7:0] cmd_buf[0:299];
  int         cmd_n = 0;
  logic [7:0] fr_op[0:1023];
  int         fr_len[0:1023];
  int         nfr = 0;
  int         fcnt = 0;
  int         wr_idx = 0;
  int         proto_err = 0;
  int         busy_cfg = 0;
  bit         wel_block = 0;
  bit         wel = 0;
  int         busy_left = 0;
  bit         pend = 0;
  int         lat = 0;
  logic [7:0] resp = 8'h00;
  bit         cs_q = 0;

  logic [7:0] wr_src[0:255];
  int         wr_base = 0;
  assign wr_data = wr_src[(wr_idx - wr_base) & 255];

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] id_b(input int i);
    case (i)
      1: return 8'h3C;
      2: return 8'h5A;
      default: return 8'h17;
    endcase
  endfunction

  function automatic logic [7:0] model_rx(input int i);
    if (i == 0) return 8'hFF;
    case (fbuf[0])
      8'h05: return {6'b0, wel, (busy_left > 0)};
      8'h9F: return id_b(i);
      8'h03: if (i >= 4) return pat({fbuf[1], fbuf[2], fbuf[3]} + 24'(i - 4));
      default: ;
    endcase
    return 8'h00;
  endfunction

  task automatic end_frame();
    fr_op[nfr & 1023]  = fbuf[0];
    fr_len[nfr & 1023] = fcnt;
    nfr++;
    case (fbuf[0])
      8'h06: if (fcnt == 1 && !wel_block) wel = 1;
      8'h02, 8'h20: if (wel) begin
        busy_left = busy_cfg;
        if (busy_cfg == 0) wel = 0;
      end
      8'h05: if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) wel = 0;
      end
      default: ;
    endcase
    if (fbuf[0] == 8'h02 || fbuf[0] == 8'h20 || fbuf[0] == 8'h03 || fbuf[0] == 8'h9F) begin
      for (int i = 0; i < fcnt; i++) cmd_buf[i] = fbuf[i];
      cmd_n = fcnt;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      xfer_done <= 1'b0;
      xfer_rx   <= 8'h00;
      pend = 0; wel = 0; busy_left = 0; cs_q = 0; fcnt = 0;
    end else begin
      xfer_done <= 1'b0;
      if (spi_cs && !cs_q) fcnt = 0;
      if (!spi_cs && cs_q) end_frame();
      if (pend) begin
        if (lat == 0) begin
          xfer_done <= 1'b1;
          xfer_rx   <= resp;
          pend = 0;
        end else lat = lat - 1;
      end
      if (xfer_start) begin
        if (pend || !spi_cs) proto_err++;
        if (fcnt < 300) begin
          fbuf[fcnt] = xfer_tx;
          resp = model_rx(fcnt);
        end
        fcnt++;
        pend = 1;
        lat  = 1;
      end
      if (wr_take) wr_idx++;
      cs_q = spi_cs;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk(req_ready == 1'b1 && spi_cs == 1'b0 && done == 1'b0 && xfer_start == 1'b0,
        "R1", "reset state", {req_ready, spi_cs, done, xfer_start}, 4'b1000);
  endtask

  logic [7:0] exp_op[0:63];
  int         exp_len[0:63];
  int         exp_n;

  task automatic add_exp(input logic [7:0] o, input int l);
    exp_op[exp_n]  = o;
    exp_len[exp_n] = l;
    exp_n++;
  endtask

  task automatic run(input int op, input logic [23:0] addr, input int len,
                     input int b, input int l, input bit wb);
    bit   bad;
    int   leff, polls, exp_err, fbase, rd_cnt, rd_bad, guard, fbad, cbad, exp_rd;
    string tag;
    @(negedge clk);
    busy_cfg   = b;
    wel_block  = wb;
    poll_limit = 24'(l);
    for (int i = 0; i < 256; i++) wr_src[i] = 8'($urandom);
    wr_base  = wr_idx;
    fbase    = nfr;
    req_op   = 2'(op);
    req_addr = addr;
    req_len  = 9'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rd_cnt = 0; rd_bad = 0; guard = 0;
    while (!done && guard < 20000) begin
      if (rd_valid) begin
        if (op == 3) begin
          if (rd_data != id_b(rd_cnt + 1)) rd_bad++;
        end else if (rd_data != pat(addr + 24'(rd_cnt))) rd_bad++;
        rd_cnt++;
      end
      @(negedge clk);
      guard++;
    end
    chk(guard < 20000, "R8", "request completes", guard, 0);

    // Expected outcome from the requirements.
    bad  = (op == 1 && (len == 0 || int'(addr[7:0]) + len > 256)) || (op == 0 && len == 0);
    leff = (l < 1) ? 1 : l;
    exp_n = 0;
    exp_err = 0;
    polls = 0;
    if (bad) begin
      exp_err = 1; tag = "R10";
    end else if (op == 0) begin
      add_exp(8'h03, 4 + len); tag = "R2";
    end else if (op == 3) begin
      add_exp(8'h9F, 4); tag = "R3";
    end else begin
      add_exp(8'h06, 1);
      add_exp(8'h05, 2);
      if (wb) begin
        exp_err = 2; tag = "R5";
      end else begin
        add_exp(op == 1 ? 8'h02 : 8'h20, op == 1 ? 4 + len : 4);
        if (b >= leff) begin polls = leff; exp_err = 3; tag = "R9"; end
        else begin polls = b + 1; tag = (op == 1) ? "R6" : "R7"; end
        for (int i = 0; i < polls; i++) add_exp(8'h05, 2);
      end
    end
    @(negedge clk);
    chk(int'(err_kind) == exp_err, tag, "error kind", err_kind, exp_err);

    // R4 R8 R11: frame list (ordering, lengths, separation)
    fbad = 0;
    if (nfr - fbase != exp_n) fbad = 1;
    else for (int i = 0; i < exp_n; i++)
      if (fr_op[(fbase + i) & 1023] != exp_op[i] || fr_len[(fbase + i) & 1023] != exp_len[i]) fbad = 1;
    chk(fbad == 0, (op == 1 || op == 2) ? "R4" : tag, "frame sequence count", nfr - fbase, exp_n);
    chk(proto_err == 0, "R11", "one byte in flight within cs", proto_err, 0);

    if (!bad && (op == 0 || op == 3 || ((op == 1 || op == 2) && !wb))) begin
      cbad = 0;
      for (int i = 1; i < 4 && (op != 3); i++)
        if (cmd_buf[i] != (i == 1 ? addr[23:16] : i == 2 ? addr[15:8] : addr[7:0])) cbad++;
      if (op == 1)
        for (int i = 0; i < len; i++) if (cmd_buf[4 + i] != wr_src[i]) cbad++;
      chk(cbad == 0, tag, "command frame bytes", cbad, 0);
    end
    if (op == 1 && !bad)
      chk(wr_idx - wr_base == (wb ? 0 : len), "R6", "wr_take count", wr_idx - wr_base, wb ? 0 : len);
    exp_rd = bad ? 0 : (op == 0 ? len : (op == 3 ? 3 : 0));
    chk(rd_cnt == exp_rd && rd_bad == 0, (op == 3) ? "R3" : "R2", "read bytes returned", rd_cnt, exp_rd);
    if (exp_err == 3) do_reset();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int op, len, b, l;
    logic [23:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) wr_src[i] = 8'h00;
    do_reset();
    // Directed corners
    run(0, 24'hFFFFFF, 1, 0, 4, 0);     // R2 address wrap
    run(0, 24'h012300, 256, 0, 4, 0);   // R2 long read
    run(3, 24'h000000, 0, 0, 4, 0);     // R3
    run(1, 24'h004500, 256, 2, 5, 0);   // R6 full page
    run(1, 24'h0045FF, 1, 1, 5, 0);     // R6 last byte of page
    run(1, 24'h0045FF, 2, 0, 5, 0);     // R10 crossing
    run(1, 24'h004501, 256, 0, 5, 0);   // R10 crossing full length
    run(1, 24'h004500, 0, 0, 5, 0);     // R10 empty program
    run(0, 24'h004500, 0, 0, 5, 0);     // R10 empty read
    run(2, 24'h0A1000, 0, 0, 3, 0);     // R7 not busy
    run(2, 24'h0A1000, 0, 5, 3, 0);     // R9 timeout
    run(2, 24'h0B2000, 0, 2, 3, 0);     // R8 clears before limit
    run(1, 24'h000010, 4, 0, 3, 1);     // R5 latch not set
    run(1, 24'h000020, 3, 3, 0, 0);     // R9 zero limit acts as one
    // Constrained random mix
    for (int t = 0; t < 30; t++) begin
      op  = $urandom_range(0, 3);
      a   = 24'($urandom);
      len = $urandom_range(0, 40);
      if (op == 1 && ($urandom_range(0, 3) != 0)) a[7:0] = 8'(256 - len - $urandom_range(0, 8));
      b   = $urandom_range(0, 4);
      l   = $urandom_range(1, 6);
      run(op, a, len, b, l, ($urandom_range(0, 7) == 0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule